// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-transfer datapath of a single DMA channel. Software programs a page number, a starting address, a transfer count (one less than the number of transfers) and two mode bits: word mode and automatic re-initialisation. Once the channel is enabled, each transfer strobe from the bus side consumes one transfer. On that strobe the current address steps forward by one and the count steps down by one. The block flags terminal count on the last transfer.

The physical bus address is formed from the page and the 16-bit current address. In byte mode the page supplies the upper eight bits. In word mode the address is shifted left by one, page bit 0 is dropped and bit 0 of the bus address is always zero. The page never changes during a transfer, so the 16-bit address wraps inside a fixed 64K-byte or 128K-byte window.

At terminal count a channel without re-initialisation disarms itself. A channel with re-initialisation restores its programmed address and count and stays armed.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, busy, term_count, word_xfer and bus_addr are all 0.
- R2: With word mode clear, bus_addr equals {page[7:0], current address[15:0]} and word_xfer is 0.
- R3: With word mode set, bus_addr equals {page[7:1], current address[15:0], 1'b0}, so bus_addr bit 0 is 0, and word_xfer is 1.
- R4: An accepted strobe (strobe high, busy high, no load in that cycle) raises the current address by one on the next clock edge. The address wraps from 0xFFFF to 0x0000, and the page bits of bus_addr do not change.
- R5: term_count is high, in the same cycle as the strobe, exactly when an accepted strobe finds the current count at 0x0000. A loaded count of N-1 therefore gives terminal count on the Nth accepted strobe. On every other accepted strobe the count falls by one.
- R6: At terminal count with auto-init clear, busy falls on the next edge, unless enable is pulsed in the same cycle. Later strobes are then ignored.
- R7: At terminal count with auto-init set, the current address and count are restored from the programmed values and busy stays high.
- R8: While busy is low, strobes have no effect: bus_addr is unchanged and term_count stays 0.
- R9: A chan_enable pulse sets busy and a chan_disable pulse clears it. When both are high in one cycle, disable takes precedence.
- R10: cfg_load writes the page, address, count and both mode bits at the next edge, whether or not the channel is busy. In a cycle with cfg_load high, a strobe is not accepted and term_count stays 0. Loading does not change busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load programmed page, address, count and mode |
| cfg_page | input | 8 | Page number to load |
| cfg_addr | input | 16 | Start address to load |
| cfg_count | input | 16 | Transfer count minus one |
| cfg_auto_init | input | 1 | Re-initialise on terminal count |
| cfg_word_mode | input | 1 | 16-bit transfers, address shifted left by one |
| chan_enable | input | 1 | Arm (unmask) the channel |
| chan_disable | input | 1 | Disarm (mask) the channel |
| xfer_strobe | input | 1 | One transfer completed on the bus |
| bus_addr | output | 24 | Physical address of the current transfer |
| word_xfer | output | 1 | High for 16-bit transfers |
| term_count | output | 1 | Current strobe is the last transfer |
| busy | output | 1 | Channel armed and accepting strobes |

## Verification
The assertions assume that control inputs are stable, 0-or-1 values at each clock edge after the internal reset release. They do not assume that enable, disable, load and strobe are mutually exclusive. Stimulus is therefore driven on the falling edge, and the random phase deliberately overlaps these controls in the same cycle, so the precedence rules are exercised. Loaded counts are mostly small and start addresses are often near 0xFFFF, so that terminal count, re-initialisation and address wrap occur many times within the run.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  // Operation applied to the current address/count registers this cycle
  typedef enum logic [1:0] {
    CUR_HOLD   = 2'd0,
    CUR_STEP   = 2'd1,
    CUR_RELOAD = 2'd2,
    CUR_LOAD   = 2'd3
  } cur_op_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_xfer_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cur_op_e           op,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_count,
  input  logic              cfg_auto_init,
  input  logic              cfg_word_mode,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              count_zero,
  output logic              auto_init,
  output logic              word_mode
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [PAGE_W-1:0] page_q,      page_d;
  logic [ADDR_W-1:0] base_addr_q, base_addr_d;
  logic [ADDR_W-1:0] base_cnt_q,  base_cnt_d;
  logic [ADDR_W-1:0] cur_addr_q,  cur_addr_d;
  logic [ADDR_W-1:0] cur_cnt_q,   cur_cnt_d;
  logic              auto_q,      auto_d;
  logic              word_q,      word_d;
  logic              cfg_en;
  logic              cur_en;

  // Clock enables: programmed copies only on load, current copies on any op
  assign cfg_en = (op == CUR_LOAD);
  assign cur_en = (op != CUR_HOLD);

  always_comb begin
    page_d      = page_q;
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    auto_d      = auto_q;
    word_d      = word_q;
    if (cfg_en) begin
      page_d      = cfg_page;
      base_addr_d = cfg_addr;
      base_cnt_d  = cfg_count;
      auto_d      = cfg_auto_init;
      word_d      = cfg_word_mode;
    end
  end

  always_comb begin
    cur_addr_d = cur_addr_q;
    cur_cnt_d  = cur_cnt_q;
    unique case (op)
      CUR_LOAD: begin
        cur_addr_d = cfg_addr;
        cur_cnt_d  = cfg_count;
      end
      CUR_RELOAD: begin
        cur_addr_d = base_addr_q;
        cur_cnt_d  = base_cnt_q;
      end
      CUR_STEP: begin
        // address wraps inside the page; no carry into the page register
        cur_addr_d = cur_addr_q + ONE;
        cur_cnt_d  = cur_cnt_q - ONE;
      end
      default: begin
        cur_addr_d = cur_addr_q;
        cur_cnt_d  = cur_cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q      <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      auto_q      <= 1'b0;
      word_q      <= 1'b0;
    end else if (cfg_en) begin
      page_q      <= page_d;
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      auto_q      <= auto_d;
      word_q      <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_q <= '0;
      cur_cnt_q  <= '0;
    end else if (cur_en) begin
      cur_addr_q <= cur_addr_d;
      cur_cnt_q  <= cur_cnt_d;
    end
  end

  assign page       = page_q;
  assign cur_addr   = cur_addr_q;
  assign count_zero = (cur_cnt_q == '0);
  assign auto_init  = auto_q;
  assign word_mode  = word_q;

  AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CUR_STEP) |=> (cur_addr_q == $past(cur_addr_q) + ONE)); // R4
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CUR_STEP) |=> (cur_cnt_q == $past(cur_cnt_q) - ONE)); // R5
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CUR_RELOAD) |=> (cur_addr_q == base_addr_q && cur_cnt_q == base_cnt_q)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CUR_HOLD) |=> ($stable(cur_addr_q) && $stable(cur_cnt_q))); // R8
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CUR_LOAD) |=> (cur_addr_q == $past(cfg_addr) && page_q == $past(cfg_page))); // R10

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_load,
  input  logic    chan_enable,
  input  logic    chan_disable,
  input  logic    xfer_strobe,
  input  logic    auto_init,
  input  logic    count_zero,
  output logic    armed,
  output logic    term_count,
  output cur_op_e op
);

  logic armed_q, armed_d;
  logic accept;

  // A strobe counts only on an armed channel and never alongside a load
  assign accept     = xfer_strobe & armed_q & ~cfg_load;
  assign term_count = accept & count_zero;

  always_comb begin
    if (cfg_load)                      op = CUR_LOAD;
    else if (term_count && auto_init)  op = CUR_RELOAD;
    else if (accept)                   op = CUR_STEP;
    else                               op = CUR_HOLD;
  end

  always_comb begin
    armed_d = armed_q;
    if (chan_disable)                    armed_d = 1'b0;
    else if (chan_enable)                armed_d = 1'b1;
    else if (term_count && !auto_init)   armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

  AST_TC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (term_count && !auto_init && !chan_enable) |=> !armed_q); // R6
  AST_TC_AUTO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (term_count && auto_init && !chan_disable) |=> armed_q); // R7
  AST_MASKED_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !term_count); // R8
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_disable |=> !armed_q); // R9
  AST_LOAD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !chan_enable && !chan_disable) |=> (armed_q == $past(armed_q))); // R10

endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [PAGE_W-1:0]        page,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic                     word_mode,
  output logic [PAGE_W+ADDR_W-1:0] phys_addr
);

  localparam int PHYS_W = PAGE_W + ADDR_W;

  logic [PHYS_W-1:0] byte_addr;
  logic [PHYS_W-1:0] word_addr;

  assign byte_addr = {page, cur_addr};

  generate
    if (PAGE_W > 1) begin : g_wide_page
      // upper page bits kept, page bit 0 replaced by the shifted address
      assign word_addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
    end else begin : g_narrow_page
      assign word_addr = {cur_addr, 1'b0};
    end
  endgenerate

  assign phys_addr = word_mode ? word_addr : byte_addr;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load,
  input  logic [PAGE_W-1:0]        cfg_page,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [ADDR_W-1:0]        cfg_count,
  input  logic                     cfg_auto_init,
  input  logic                     cfg_word_mode,
  input  logic                     chan_enable,
  input  logic                     chan_disable,
  input  logic                     xfer_strobe,
  output logic [PAGE_W+ADDR_W-1:0] bus_addr,
  output logic                     word_xfer,
  output logic                     term_count,
  output logic                     busy
);

  localparam int PHYS_W = PAGE_W + ADDR_W;

  logic              rst_sync_n;
  cur_op_e           op;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] cur_addr;
  logic              count_zero;
  logic              auto_init;
  logic              word_mode;
  logic              armed;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_chan_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_load     (cfg_load),
    .chan_enable  (chan_enable),
    .chan_disable (chan_disable),
    .xfer_strobe  (xfer_strobe),
    .auto_init    (auto_init),
    .count_zero   (count_zero),
    .armed        (armed),
    .term_count   (term_count),
    .op           (op)
  );

  dma_chan_regs #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .op            (op),
    .cfg_page      (cfg_page),
    .cfg_addr      (cfg_addr),
    .cfg_count     (cfg_count),
    .cfg_auto_init (cfg_auto_init),
    .cfg_word_mode (cfg_word_mode),
    .page          (page),
    .cur_addr      (cur_addr),
    .count_zero    (count_zero),
    .auto_init     (auto_init),
    .word_mode     (word_mode)
  );

  dma_addr_map #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_map (
    .page      (page),
    .cur_addr  (cur_addr),
    .word_mode (word_mode),
    .phys_addr (bus_addr)
  );

  assign word_xfer = word_mode;
  assign busy      = armed;

  AST_WORD_A0_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_xfer |-> (bus_addr[0] == 1'b0)); // R3
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_load |=> $stable(bus_addr[PHYS_W-1:ADDR_W+1])); // R4

endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load, cfg_auto_init, cfg_word_mode;
  logic [7:0]  cfg_page;
  logic [15:0] cfg_addr, cfg_count;
  logic        chan_enable, chan_disable, xfer_strobe;
  logic [23:0] bus_addr;
  logic        word_xfer, term_count, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the channel
  logic [7:0]  m_page;
  logic [15:0] m_addr, m_cnt, m_base_addr, m_base_cnt;
  logic        m_auto, m_word, m_armed;

  always #2 clk = ~clk;

  dma_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_page(cfg_page),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_auto_init(cfg_auto_init),
    .cfg_word_mode(cfg_word_mode), .chan_enable(chan_enable),
    .chan_disable(chan_disable), .xfer_strobe(xfer_strobe),
    .bus_addr(bus_addr), .word_xfer(word_xfer), .term_count(term_count),
    .busy(busy)
  );

  function automatic logic [23:0] exp_addr(input logic [7:0] pg, input logic [15:0] a,
                                           input logic wd);
    return wd ? {pg[7:1], a, 1'b0} : {pg, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called on a falling edge: drive inputs, check term_count, advance one clock,
  // update the model, then check outputs on the next falling edge.
  task automatic step(input string tag, input logic ld, input logic en, input logic dis,
                      input logic stb, input logic [7:0] pg, input logic [15:0] ad,
                      input logic [15:0] ct, input logic au, input logic wd);
    logic acc, tc;
    cfg_load = ld; chan_enable = en; chan_disable = dis; xfer_strobe = stb;
    cfg_page = pg; cfg_addr = ad; cfg_count = ct; cfg_auto_init = au; cfg_word_mode = wd;
    acc = stb & m_armed & ~ld;
    tc  = acc & (m_cnt == 16'h0000);
    #1;
    check({tag, " term_count (R5)"}, {31'd0, term_count}, {31'd0, tc});
    @(posedge clk);
    if (ld) begin
      m_page = pg; m_base_addr = ad; m_base_cnt = ct; m_auto = au; m_word = wd;
      m_addr = ad; m_cnt = ct;
    end else if (acc) begin
      if (tc && m_auto) begin
        m_addr = m_base_addr; m_cnt = m_base_cnt;
      end else begin
        m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
      end
    end
    if (dis)                m_armed = 1'b0;
    else if (en)            m_armed = 1'b1;
    else if (tc && !m_auto) m_armed = 1'b0;
    @(negedge clk);
    check({tag, " bus_addr"}, {8'd0, bus_addr}, {8'd0, exp_addr(m_page, m_addr, m_word)});
    check({tag, " busy (R9)"}, {31'd0, busy}, {31'd0, m_armed});
    check({tag, " word_xfer"}, {31'd0, word_xfer}, {31'd0, m_word});
    cfg_load = 0; chan_enable = 0; chan_disable = 0; xfer_strobe = 0;
  endtask

  task automatic idle_strobe(input string tag);
    step(tag, 0, 0, 0, 1, 8'h00, 16'h0000, 16'h0000, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250117));
    rst_n = 0;
    cfg_load = 0; chan_enable = 0; chan_disable = 0; xfer_strobe = 0;
    cfg_page = 0; cfg_addr = 0; cfg_count = 0; cfg_auto_init = 0; cfg_word_mode = 0;
    m_page = 0; m_addr = 0; m_cnt = 0; m_base_addr = 0; m_base_cnt = 0;
    m_auto = 0; m_word = 0; m_armed = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 term_count", {31'd0, term_count}, 32'd0);
    check("R1 word_xfer", {31'd0, word_xfer}, 32'd0);
    check("R1 bus_addr", {8'd0, bus_addr}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: load while idle, busy unchanged; R2 byte mapping
    step("R10 load", 1, 0, 0, 0, 8'h12, 16'hFFFE, 16'h0002, 0, 0);
    check("R2 byte map", {8'd0, bus_addr}, 32'h0012FFFE);
    check("R10 busy after load", {31'd0, busy}, 32'd0);
    // R8: strobe on masked channel ignored
    idle_strobe("R8 masked strobe");
    check("R8 addr held", {8'd0, bus_addr}, 32'h0012FFFE);
    // R9 enable, then R4 wrap with page fixed, R5 tc on third strobe, R6 disarm
    step("R9 enable", 0, 1, 0, 0, 8'h00, 16'h0, 16'h0, 0, 0);
    idle_strobe("R4 step1");
    idle_strobe("R4 step2 wrap");
    check("R4 wrap page fixed", {8'd0, bus_addr}, 32'h00120000);
    idle_strobe("R5 tc strobe");
    check("R6 busy cleared", {31'd0, busy}, 32'd0);
    idle_strobe("R6 strobe after tc");
    check("R6 addr held", {8'd0, bus_addr}, 32'h00120001);

    // R3 word mapping, R7 auto-init reload
    step("R3 load word", 1, 0, 0, 0, 8'h35, 16'h1234, 16'h0001, 1, 1);
    check("R3 word map", {8'd0, bus_addr}, 32'h00342468);
    check("R3 word_xfer", {31'd0, word_xfer}, 32'd1);
    step("R9 enable", 0, 1, 0, 0, 8'h00, 16'h0, 16'h0, 0, 0);
    idle_strobe("R3 step");
    check("R3 word step", {8'd0, bus_addr}, 32'h0034246A);
    idle_strobe("R7 tc reload");
    check("R7 reloaded", {8'd0, bus_addr}, 32'h00342468);
    check("R7 still busy", {31'd0, busy}, 32'd1);

    // R10: load with strobe while busy: load wins
    step("R10 load+strobe", 1, 0, 0, 1, 8'hA0, 16'h0000, 16'h0000, 0, 0);
    check("R10 load wins", {8'd0, bus_addr}, 32'h00A00000);
    check("R10 busy kept", {31'd0, busy}, 32'd1);
    // R9: enable and disable together, disable wins
    step("R9 en+dis", 0, 1, 1, 0, 8'h00, 16'h0, 16'h0, 0, 0);
    check("R9 disable wins", {31'd0, busy}, 32'd0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic ld, en, dis, stb, au, wd;
      logic [7:0] pg;
      logic [15:0] ad, ct;
      ld  = ($urandom_range(0, 15) == 0);
      en  = ($urandom_range(0, 7) == 0);
      dis = ($urandom_range(0, 40) == 0);
      stb = ($urandom_range(0, 3) != 0);
      au  = $urandom_range(0, 1) != 0;
      wd  = $urandom_range(0, 1) != 0;
      pg  = 8'($urandom);
      ad  = ($urandom_range(0, 1) != 0) ? 16'hFFFF - 16'($urandom_range(0, 4)) : 16'($urandom);
      ct  = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(0, 300)) : 16'($urandom_range(0, 5));
      step(m_word ? "R3/R4 random" : "R2/R4 random", ld, en, dis, stb, pg, ad, ct, au, wd);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule